// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register File

This block is the host-facing register file of a descriptor-driven Ethernet controller. The host sees two addresses. Address 1 holds a 2-bit pointer. Address 0 is a data window onto whichever of four 16-bit control/status registers the pointer selects. Register 0 is the command/status word. It mixes one-shot commands, event flags that software clears by writing 1, enable bits and two summary bits. Registers 1 to 3 are plain storage. Registers 1 and 2 carry the 24-bit start address of the setup block, and register 3 carries bus configuration.

The internal setup, transmit and receive engines raise event flags through single-cycle set pulses. They read back the receiver/transmitter run enables, the pending setup request and the transmit poll demand. When setup finishes, the setup engine clears the request and starts the data paths. When the transmit engine accepts a poll, it drops the demand. The block gathers its interrupt sources into one interrupt output, gated by a host enable bit.

Top module: `eth_csr_regs`

## Requirements
- R1: A host write at address 1 keeps only data bits 1:0 as the register pointer. A read at address 1 returns the pointer zero-extended to 16 bits.
- R2: Host reads and writes at address 0 go to the register the pointer selects. Writes to registers 1 to 3 store all 16 bits. The setup address output is {register 2 bits 7:0, register 1}. The bus configuration output is register 3.
- R3: In register 0, the flags at bits 14 (babble), 13 (collision), 12 (missed frame), 11 (memory error), 10 (receive done), 9 (transmit done) and 8 (setup done) are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R4: The commands at bits 3 (transmit demand), 1 (start) and 0 (setup) are set only by a host write of 1. Writing 0 to them has no effect. Setting start or setup also clears the stop bit (bit 2).
- R5: Writing 1 to stop (bit 2) sets stop and clears start and setup, even when those are written as 1 in the same write.
- R6: Interrupt enable (bit 6) takes the written value on every write to register 0.
- R7: Bit 15 reads as the OR of bits 14, 13, 12 and 11. Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8. Both are derived from the current flags and are never stored.
- R8: While the memory error flag is set, receive run (bit 5) and transmit run (bit 4) read 0. While stop is set, setup done reads 0.
- R9: After reset, register 0 reads 0x0004, the pointer reads 0, and registers 1 to 3 read 0.
- R10: `irq` is high exactly when bit 7 and bit 6 of register 0 are both 1.
- R11: `evt_set[k]` sets the flag at bit 8+k. An engine set pulse wins over a host write-1-to-clear of the same flag in the same cycle.
- R12: A `setup_done` pulse clears the setup bit and sets setup done. It also loads receive run with NOT `no_rx` and transmit run with NOT `no_tx`. A `tx_taken` pulse clears transmit demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = data window, 1 = register pointer |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| evt_set | input | 7 | Flag set pulses; bit k sets register 0 bit 8+k |
| setup_done | input | 1 | Setup engine finished pulse |
| no_rx | input | 1 | Keep receiver off at setup completion |
| no_tx | input | 1 | Keep transmitter off at setup completion |
| tx_taken | input | 1 | Transmit engine accepted the poll demand |
| run_rx | output | 1 | Receive run enable |
| run_tx | output | 1 | Transmit run enable |
| setup_req | output | 1 | Setup requested |
| tx_demand | output | 1 | Transmit poll demand |
| setup_addr | output | 24 | Setup block start address |
| bus_cfg | output | 16 | Register 3 contents |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same cycle. A host write-1-to-clear of an event flag can coincide with an engine set pulse for that same flag. A stop command can arrive in the same write as start and setup. The bench drives both collisions deliberately: a clearing write together with a pulse on the same flag, and one write that sets stop, start and setup at once. It judges each case by reading register 0 back through the data window. The pulse must win, and stop must win. It also checks that a setup-done pulse arriving while stop is set leaves setup done at 0.

// File: rtl/eth_csr_pkg.sv
// Package: bit positions of the command/status word and shared widths.
// Assumes a 16-bit command/status register; flags occupy a contiguous field.
package eth_csr_pkg;
    localparam int CSR_W    = 16;
    localparam int B_ERR    = 15;
    localparam int FLAG_LO  = 8;
    localparam int N_FLAGS  = 7;
    localparam int FLAG_HI  = FLAG_LO + N_FLAGS - 1;
    localparam int B_INTR   = 7;
    localparam int B_INEA   = 6;
    localparam int B_RXON   = 5;
    localparam int B_TXON   = 4;
    localparam int B_TDMD   = 3;
    localparam int B_STOP   = 2;
    localparam int B_STRT   = 1;
    localparam int B_INIT   = 0;
    // flag indices inside the flag field (bit FLAG_LO + k)
    localparam int K_BABL   = 6;
    localparam int K_CERR   = 5;
    localparam int K_MISS   = 4;
    localparam int K_MERR   = 3;
    localparam int K_RINT   = 2;
    localparam int K_TINT   = 1;
    localparam int K_IDON   = 0;
endpackage

// File: rtl/csr_select.sv
// Register pointer: holds the index of the register behind the data window
// and decodes host writes into one write enable per register.
// Assumes a single host write per cycle.
module csr_select #(
    parameter int NUM_CSR = 4,
    localparam int SEL_W  = $clog2(NUM_CSR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_addr,
    input  logic [SEL_W-1:0]   sel_wdata,
    output logic [SEL_W-1:0]   sel_q,
    output logic [NUM_CSR-1:0] wr_en
);
    // Pointer register: loads on writes to the pointer address.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sel_q <= '0;
        else if (host_wr && host_addr) sel_q <= sel_wdata;
    end

    // One-hot write enable for the register currently selected.
    always_comb begin
        wr_en = '0;
        if (host_wr && !host_addr) wr_en[sel_q] = 1'b1;
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr |=> sel_q == $past(sel_wdata)); // R1
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R2
endmodule

// File: rtl/csr_aux_bank.sv
// Plain storage registers 1..NUM_CSR-1: full-width load on their enable.
// Assumes enables are one-hot or zero.
module csr_aux_bank #(
    parameter int NUM_CSR = 4,
    parameter int DATA_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CSR-1:1]              wr_en,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_CSR-1:1][DATA_W-1:0]  aux_q
);
    for (genvar i = 1; i < NUM_CSR; i++) begin : g_reg
        // Storage register i: takes the full written value.
        always_ff @(posedge clk) begin
            if (!rst_n)        aux_q[i] <= '0;
            else if (wr_en[i]) aux_q[i] <= wdata;
        end

        AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[i] |=> $stable(aux_q[i])); // R2
    end
endmodule

// File: rtl/csr_ctrl0.sv
// Command/status word: write-1-to-clear flags, set-only commands with stop
// priority, enable bits, derived summary bits and the interrupt output.
// Assumes engine pulses are single-cycle; set pulses beat host clears.
module csr_ctrl0
    import eth_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CSR_W-1:0]   wdata,
    input  logic [N_FLAGS-1:0] evt_set,
    input  logic               setup_done,
    input  logic               no_rx,
    input  logic               no_tx,
    input  logic               tx_taken,
    output logic [CSR_W-1:0]   csr0_rd,
    output logic               irq,
    output logic               run_rx,
    output logic               run_tx,
    output logic               setup_req,
    output logic               tx_demand
);
    logic [N_FLAGS-1:0] flag_q, flag_d, flag_mid, clr, evt_all;
    logic inea_q, rxon_q, txon_q, tdmd_q, stop_q, strt_q, init_q;
    logic inea_d, rxon_d, txon_d, tdmd_d, stop_d, strt_d, init_d;
    logic err_sum, int_sum;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};

    // Next-state: clears, then set pulses, then command priority and forcing.
    always_comb begin
        clr      = wr_en ? wdata[FLAG_HI:FLAG_LO] : '0;
        evt_all  = evt_set;
        evt_all[K_IDON] = evt_set[K_IDON] | setup_done;
        flag_mid = (flag_q & ~clr) | evt_all;

        inea_d = wr_en ? wdata[B_INEA] : inea_q;
        tdmd_d = tdmd_q & ~tx_taken;
        init_d = init_q & ~setup_done;
        strt_d = strt_q;
        stop_d = stop_q;
        if (wr_en) begin
            if (wdata[B_TDMD]) tdmd_d = 1'b1;
            if (wdata[B_STRT]) begin strt_d = 1'b1; stop_d = 1'b0; end
            if (wdata[B_INIT]) begin init_d = 1'b1; stop_d = 1'b0; end
            if (wdata[B_STOP]) begin stop_d = 1'b1; strt_d = 1'b0; init_d = 1'b0; end
        end

        flag_d = flag_mid;
        flag_d[K_IDON] = flag_mid[K_IDON] & ~stop_d;

        rxon_d = (setup_done ? ~no_rx : rxon_q) & ~flag_d[K_MERR];
        txon_d = (setup_done ? ~no_tx : txon_q) & ~flag_d[K_MERR];
    end

    // State register of the command/status word; reset leaves only stop set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            inea_q <= 1'b0; rxon_q <= 1'b0; txon_q <= 1'b0;
            tdmd_q <= 1'b0; stop_q <= 1'b1; strt_q <= 1'b0; init_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            inea_q <= inea_d; rxon_q <= rxon_d; txon_q <= txon_d;
            tdmd_q <= tdmd_d; stop_q <= stop_d; strt_q <= strt_d; init_q <= init_d;
        end
    end

    // Summary bits derived from the stored flags every cycle.
    always_comb begin
        err_sum = flag_q[K_BABL] | flag_q[K_CERR] | flag_q[K_MISS] | flag_q[K_MERR];
        int_sum = flag_q[K_BABL] | flag_q[K_MISS] | flag_q[K_MERR] |
                  flag_q[K_RINT] | flag_q[K_TINT] | flag_q[K_IDON];
    end

    // Read image assembly and engine-facing outputs.
    always_comb begin
        csr0_rd = {err_sum, flag_q, int_sum, inea_q, rxon_q, txon_q,
                   tdmd_q, stop_q, strt_q, init_q};
    end

    assign irq       = int_sum & inea_q;
    assign run_rx    = rxon_q;
    assign run_tx    = txon_q;
    assign setup_req = init_q;
    assign tx_demand = tdmd_q;

    AST_FLAG_ONLY_BY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_set | {{(N_FLAGS-1){1'b0}}, setup_done})) == '0)); // R3
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[B_STOP] |=> stop_q && !strt_q && !init_q); // R5
    AST_MERR_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[K_MERR] |-> !rxon_q && !txon_q); // R8
    AST_STOP_NO_IDON: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> !flag_q[K_IDON]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[N_FLAGS-1:1] != '0 |=>
        ((flag_q[N_FLAGS-1:1] & $past(evt_set[N_FLAGS-1:1])) == $past(evt_set[N_FLAGS-1:1]))); // R11
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> inea_q && csr0_rd[B_INTR]); // R10
endmodule

// File: rtl/eth_csr_regs.sv
// Top: host register file of the Ethernet controller. A pointer selects one
// of NUM_CSR registers behind the data window; register 0 is the
// command/status word, the rest are plain storage.
// Assumes host reads are combinational and side-effect free.
module eth_csr_regs
    import eth_csr_pkg::*;
#(
    parameter int NUM_CSR   = 4,
    parameter int ADDR_HI_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_addr,
    input  logic [CSR_W-1:0]         host_wdata,
    output logic [CSR_W-1:0]         host_rdata,
    input  logic [N_FLAGS-1:0]       evt_set,
    input  logic                     setup_done,
    input  logic                     no_rx,
    input  logic                     no_tx,
    input  logic                     tx_taken,
    output logic                     run_rx,
    output logic                     run_tx,
    output logic                     setup_req,
    output logic                     tx_demand,
    output logic [CSR_W+ADDR_HI_W-1:0] setup_addr,
    output logic [CSR_W-1:0]         bus_cfg,
    output logic                     irq
);
    localparam int SEL_W = $clog2(NUM_CSR);

    logic [SEL_W-1:0]              sel_q;
    logic [NUM_CSR-1:0]            wr_en;
    logic [NUM_CSR-1:1][CSR_W-1:0] aux_q;
    logic [CSR_W-1:0]              csr0_rd;
    logic                          unused_hi;

    csr_select #(.NUM_CSR(NUM_CSR)) u_sel (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .sel_wdata(host_wdata[SEL_W-1:0]), .sel_q(sel_q), .wr_en(wr_en));

    csr_aux_bank #(.NUM_CSR(NUM_CSR), .DATA_W(CSR_W)) u_aux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[NUM_CSR-1:1]),
        .wdata(host_wdata), .aux_q(aux_q));

    csr_ctrl0 u_ctrl0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .wdata(host_wdata),
        .evt_set(evt_set), .setup_done(setup_done), .no_rx(no_rx),
        .no_tx(no_tx), .tx_taken(tx_taken), .csr0_rd(csr0_rd), .irq(irq),
        .run_rx(run_rx), .run_tx(run_tx), .setup_req(setup_req),
        .tx_demand(tx_demand));

    // Host read mux: pointer at address 1, selected register at address 0.
    always_comb begin
        if (host_addr)          host_rdata = {{(CSR_W-SEL_W){1'b0}}, sel_q};
        else if (sel_q == '0)   host_rdata = csr0_rd;
        else                    host_rdata = aux_q[sel_q];
    end

    assign setup_addr = {aux_q[2][ADDR_HI_W-1:0], aux_q[1]};
    assign bus_cfg    = aux_q[NUM_CSR-1];
    assign unused_hi  = ^aux_q[2][CSR_W-1:ADDR_HI_W];
endmodule

// File: tb/tb_eth_csr_regs.sv
`timescale 1ns/100ps
module tb_eth_csr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_addr = 1'b0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic [6:0]  evt_set = '0;
    logic        setup_done = 1'b0, no_rx = 1'b0, no_tx = 1'b0, tx_taken = 1'b0;
    logic        run_rx, run_tx, setup_req, tx_demand, irq;
    logic [23:0] setup_addr;
    logic [15:0] bus_cfg;

    int n_chk = 0, n_fail = 0;
    bit done = 0, probe = 0;

    typedef struct { int which; logic [23:0] exp; string tag; } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    eth_csr_regs dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
        .setup_done(setup_done), .no_rx(no_rx), .no_tx(no_tx),
        .tx_taken(tx_taken), .run_rx(run_rx), .run_tx(run_tx),
        .setup_req(setup_req), .tx_demand(tx_demand), .setup_addr(setup_addr),
        .bus_cfg(bus_cfg), .irq(irq));

    // Monitor: pops the expected item and compares it with the observed value.
    always @(negedge clk) begin
        #1;
        if (probe && sb.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it = sb.pop_front();
            case (it.which)
                0: act = {8'h0, host_rdata};
                1: act = {19'h0, irq, run_rx, run_tx, setup_req, tx_demand};
                default: act = setup_addr;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input int which, input logic a, input logic [23:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        host_addr = a;
        it.which = which; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        probe = 1;
        @(negedge clk);
        probe = 0;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic pulse_evt(input logic [6:0] e);
        @(negedge clk); evt_set = e;
        @(negedge clk); evt_set = '0;
    endtask

    task automatic pulse_setup(input logic nr, input logic nt);
        @(negedge clk); setup_done = 1; no_rx = nr; no_tx = nt;
        @(negedge clk); setup_done = 0;
    endtask

    // obs vector for which=1: {irq, run_rx, run_tx, setup_req, tx_demand}
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(0, 0, 24'h0004, "R9 reset csr0");
        chk(0, 1, 24'h0000, "R9 reset pointer");
        chk(1, 0, 24'h00000, "R9 reset outputs");
        // R1 pointer keeps two bits
        wr(1, 16'hFFF7);
        chk(0, 1, 24'h0003, "R1 pointer low bits");
        // R2 storage registers
        wr(0, 16'hBEEF);
        chk(0, 0, 24'hBEEF, "R2 csr3 readback");
        wr(1, 16'h0001); wr(0, 16'h1234);
        wr(1, 16'h0002); wr(0, 16'hFF56);
        chk(2, 0, 24'h561234, "R2 setup address");
        chk(0, 0, 24'hFF56, "R2 csr2 readback");
        wr(1, 16'h0000);
        chk(0, 0, 24'h0004, "R2 csr0 untouched by other writes");
        // R4 set-only commands
        wr(0, 16'h0002);
        chk(0, 0, 24'h0002, "R4 start clears stop");
        wr(0, 16'h0000);
        chk(0, 0, 24'h0002, "R4 zero write no effect");
        wr(0, 16'h0001);
        chk(0, 0, 24'h0003, "R4 setup set");
        chk(1, 0, 24'h02, "R4 setup_req out");
        // R5 stop wins
        wr(0, 16'h0007);
        chk(0, 0, 24'h0004, "R5 stop wins");
        // R12 setup completion
        wr(0, 16'h0001);
        chk(0, 0, 24'h0001, "R4 setup clears stop");
        pulse_setup(0, 1);
        chk(0, 0, 24'h01A0, "R12 setup done");
        chk(1, 0, 24'h08, "R12 run outputs");
        // R6/R10 interrupt enable
        wr(0, 16'h0040);
        chk(0, 0, 24'h01E0, "R6 enable set");
        chk(1, 0, 24'h18, "R10 irq high");
        // R3 W1C
        wr(0, 16'h0140);
        chk(0, 0, 24'h0060, "R3 clear setup done");
        chk(1, 0, 24'h08, "R10 irq low");
        // R7 summaries
        pulse_evt(7'b0100000);
        chk(0, 0, 24'hA060, "R7 collision -> err only");
        chk(1, 0, 24'h08, "R10 no irq for collision");
        pulse_evt(7'b1000000);
        chk(0, 0, 24'hE0E0, "R7 babble -> err and int");
        wr(0, 16'h6040);
        chk(0, 0, 24'h0060, "R3 clear two flags");
        // R11 set beats clear
        @(negedge clk);
        host_addr = 0; host_wdata = 16'h0240; host_wr = 1; evt_set = 7'b0000010;
        @(negedge clk);
        host_wr = 0; evt_set = '0;
        chk(0, 0, 24'h02E0, "R11 pulse wins over clear");
        wr(0, 16'h0240);
        chk(0, 0, 24'h0060, "R3 clear transmit done");
        // R12 transmit demand
        wr(0, 16'h0048);
        chk(0, 0, 24'h0068, "R4 demand set");
        @(negedge clk); tx_taken = 1;
        @(negedge clk); tx_taken = 0;
        chk(0, 0, 24'h0060, "R12 demand taken");
        // R8 memory error gates run bits
        pulse_evt(7'b0001000);
        chk(0, 0, 24'h88C0, "R8 merr kills run");
        wr(0, 16'h0840);
        chk(0, 0, 24'h0040, "R8 run stays off");
        // R8 stop clears setup done
        wr(0, 16'h0041);
        pulse_setup(0, 0);
        chk(0, 0, 24'h01F0, "R12 both paths on");
        wr(0, 16'h0044);
        chk(0, 0, 24'h0074, "R8 stop clears setup done");
        pulse_evt(7'b0000001);
        chk(0, 0, 24'h0074, "R8 setup done held off by stop");
        chk(1, 0, 24'h0C, "R10 irq low under stop");
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule